// File: doc/BRIEF.md
# Bidirectional Recirculating Shift Register

This block is a serial shift register of `STAGES` one-bit stages, numbered 1 to `STAGES`. On each rising clock edge it moves its contents one stage toward stage `STAGES` (right mode) or toward stage 1 (left mode). Each direction has its own serial data input. A feed-select control picks what enters the open end of the register. When it is high, the bit comes from the serial input for the active direction. When it is low, the bit comes from the stage at the other end, so the register turns into a ring. A hold input freezes every stage on an edge where it is high.

Two serial outputs show the end stages. `sout_left` shows stage 1 and `sout_right` shows stage `STAGES`. Each output is registered on the falling clock edge, so a bit loaded on a rising edge reaches the pin half a cycle later. This allows instances to be chained into a longer register. The right output of one instance drives the right input of the next instance. The left output of the next instance drives the left input of the one before.

The shift behaviour is driven by an enumerated action decoder with five actions:
- `ACT_IDLE`: hold is high, or reset is active.
- `ACT_RIGHT_FEED`: right shift, external input.
- `ACT_RIGHT_RING`: right shift, stage `STAGES` re-enters at stage 1.
- `ACT_LEFT_FEED`: left shift, external input.
- `ACT_LEFT_RING`: left shift, stage 1 re-enters at stage `STAGES`.

The action is chosen again from the control inputs on every edge; no action carries over from one edge to the next.

Top module: `bidir_ring_shifter`

## Requirements
- R1: A high `rst` sampled on a rising edge clears every stage to 0. Both outputs read 0 after the falling edge that follows while `rst` is still high.
- R2: With `dir_left`=0, `feed_ext`=1 and `hold`=0, a rising edge loads stage 1 from `sin_right`, and each stage k+1 takes the old value of stage k.
- R3: With `dir_left`=1, `feed_ext`=1 and `hold`=0, a rising edge loads stage `STAGES` from `sin_left`, and each stage k takes the old value of stage k+1.
- R4: With `dir_left`=0, `feed_ext`=0 and `hold`=0, stage 1 reloads from the old stage `STAGES`, and `sin_right` has no effect.
- R5: With `dir_left`=1, `feed_ext`=0 and `hold`=0, stage `STAGES` reloads from the old stage 1, and `sin_left` has no effect.
- R6: With `hold`=1 on a rising edge, no stage changes, whatever the other controls and serial inputs are.
- R7: `sout_left` shows stage 1 and `sout_right` shows stage `STAGES`. Each takes its new value on the falling edge after the load, and holds its old value through the high phase.
- R8: `dir_left`, `feed_ext` and `hold` must not change while the clock is high. A simulation check flags any such change.
- R9: Two instances chained right-output to right-input and left-output to left-input behave as a single register of twice the stage count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: shift on rising edge, outputs on falling edge |
| rst | input | 1 | Synchronous active-high clear, for test |
| dir_left | input | 1 | 0 selects right shift, 1 selects left shift |
| feed_ext | input | 1 | 1 takes the external serial input, 0 closes the ring |
| hold | input | 1 | 1 freezes all stages on the edge |
| sin_right | input | 1 | Serial input entering stage 1 in right mode |
| sin_left | input | 1 | Serial input entering stage `STAGES` in left mode |
| sout_left | output | 1 | Stage 1, registered on falling edge |
| sout_right | output | 1 | Stage `STAGES`, registered on falling edge |

## Verification
The bench builds one instance with the default 32 stages. This is long enough that ring rotation runs past a full turn in both directions, and the end outputs reveal the whole stored pattern over time. It also builds two 4-stage instances joined as a cascade. Their short length lets bits cross the boundary between the two instances many times in both directions, which checks that the half-cycle output register gives correct inter-instance timing. Outputs are compared in the high phase, where they must still show the old ends, and again after the falling edge.

// File: rtl/bdsr_pkg.sv
package bdsr_pkg;

    // Action chosen for one rising edge.
    typedef enum logic [2:0] {
        ACT_IDLE       = 3'd0,
        ACT_RIGHT_FEED = 3'd1,
        ACT_RIGHT_RING = 3'd2,
        ACT_LEFT_FEED  = 3'd3,
        ACT_LEFT_RING  = 3'd4
    } shift_act_e;

endpackage

// File: rtl/bdsr_mode_dec.sv
module bdsr_mode_dec
    import bdsr_pkg::*;
(
    input  logic       rst,
    input  logic       dir_left,
    input  logic       feed_ext,
    input  logic       hold,
    output shift_act_e act
);

    always_comb begin
        act = ACT_IDLE;
        unique casez ({rst, hold, dir_left, feed_ext})
            4'b1???: act = ACT_IDLE;
            4'b01??: act = ACT_IDLE;
            4'b0001: act = ACT_RIGHT_FEED;
            4'b0000: act = ACT_RIGHT_RING;
            4'b0011: act = ACT_LEFT_FEED;
            4'b0010: act = ACT_LEFT_RING;
            default: act = ACT_IDLE;
        endcase
    end

endmodule

// File: rtl/bdsr_stage_bank.sv
module bdsr_stage_bank
    import bdsr_pkg::*;
#(
    parameter int STAGES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_act_e        act,
    input  logic              sin_right,
    input  logic              sin_left,
    output logic [STAGES-1:0] stg
);

    // Bit index 0 is stage 1, index LAST is the far end.
    localparam int LAST = STAGES - 1;

    logic              entry_bit;
    logic [STAGES-1:0] nxt;

    // Bit entering the open end of the register.
    always_comb begin
        entry_bit = 1'b0;
        unique case (act)
            ACT_RIGHT_FEED: entry_bit = sin_right;
            ACT_RIGHT_RING: entry_bit = stg[LAST];
            ACT_LEFT_FEED:  entry_bit = sin_left;
            ACT_LEFT_RING:  entry_bit = stg[0];
            default:        entry_bit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic from_lower;
        logic from_upper;

        if (i == 0) begin : g_first
            assign from_lower = entry_bit;
        end else begin : g_mid_lo
            assign from_lower = stg[i-1];
        end

        if (i == LAST) begin : g_last
            assign from_upper = entry_bit;
        end else begin : g_mid_hi
            assign from_upper = stg[i+1];
        end

        always_comb begin
            nxt[i] = stg[i];
            unique case (act)
                ACT_RIGHT_FEED,
                ACT_RIGHT_RING: nxt[i] = from_lower;
                ACT_LEFT_FEED,
                ACT_LEFT_RING:  nxt[i] = from_upper;
                default:        nxt[i] = stg[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= nxt;
        end
    end

endmodule

// File: rtl/bdsr_end_taps.sv
module bdsr_end_taps (
    input  logic clk,
    input  logic rst,
    input  logic first_bit,
    input  logic last_bit,
    output logic sout_left,
    output logic sout_right
);

    // The ends are sampled half a cycle after the shift edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            sout_left  <= 1'b0;
            sout_right <= 1'b0;
        end else begin
            sout_left  <= first_bit;
            sout_right <= last_bit;
        end
    end

endmodule

// File: rtl/bidir_ring_shifter.sv
module bidir_ring_shifter
    import bdsr_pkg::*;
#(
    parameter int STAGES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic dir_left,
    input  logic feed_ext,
    input  logic hold,
    input  logic sin_right,
    input  logic sin_left,
    output logic sout_left,
    output logic sout_right
);

    localparam int LAST = STAGES - 1;

    shift_act_e        act;
    logic [STAGES-1:0] stg;

    bdsr_mode_dec u_dec (
        .rst      (rst),
        .dir_left (dir_left),
        .feed_ext (feed_ext),
        .hold     (hold),
        .act      (act)
    );

    bdsr_stage_bank #(.STAGES(STAGES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .sin_right (sin_right),
        .sin_left  (sin_left),
        .stg       (stg)
    );

    bdsr_end_taps u_taps (
        .clk        (clk),
        .rst        (rst),
        .first_bit  (stg[0]),
        .last_bit   (stg[LAST]),
        .sout_left  (sout_left),
        .sout_right (sout_right)
    );

endmodule

// File: rtl/bdsr_chk.sv
module bdsr_chk #(
    parameter int STAGES = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              dir_left,
    input logic              feed_ext,
    input logic              hold,
    input logic              sin_right,
    input logic              sin_left,
    input logic [STAGES-1:0] stg,
    input logic              sout_left,
    input logic              sout_right
);

    localparam int LAST = STAGES - 1;

    logic [2:0] ctl_at_rise;

    always_ff @(posedge clk) begin
        ctl_at_rise <= {dir_left, feed_ext, hold};
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (stg == '0)) else $error("reset clear");  // R1

    AST_RIGHT_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!hold && !dir_left) |=> (stg[LAST:1] == $past(stg[LAST-1:0]))) else $error("right move");  // R2

    AST_RIGHT_FEED: assert property (@(posedge clk) disable iff (rst)
        (!hold && !dir_left && feed_ext) |=> (stg[0] == $past(sin_right))) else $error("right feed");  // R2

    AST_LEFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!hold && dir_left) |=> (stg[LAST-1:0] == $past(stg[LAST:1]))) else $error("left move");  // R3

    AST_LEFT_FEED: assert property (@(posedge clk) disable iff (rst)
        (!hold && dir_left && feed_ext) |=> (stg[LAST] == $past(sin_left))) else $error("left feed");  // R3

    AST_RIGHT_RING: assert property (@(posedge clk) disable iff (rst)
        (!hold && !dir_left && !feed_ext) |=> (stg[0] == $past(stg[LAST]))) else $error("right ring");  // R4

    AST_LEFT_RING: assert property (@(posedge clk) disable iff (rst)
        (!hold && dir_left && !feed_ext) |=> (stg[LAST] == $past(stg[0]))) else $error("left ring");  // R5

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(stg)) else $error("hold");  // R6

    AST_END_TAPS: assert property (@(posedge clk) disable iff (rst)
        (sout_left == stg[0]) && (sout_right == stg[LAST])) else $error("end taps");  // R7

    AST_CTL_STEADY: assert property (@(negedge clk) disable iff (rst)
        ({dir_left, feed_ext, hold} == ctl_at_rise)) else $error("control moved while clock high");  // R8

endmodule

bind bidir_ring_shifter bdsr_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir_left   (dir_left),
    .feed_ext   (feed_ext),
    .hold       (hold),
    .sin_right  (sin_right),
    .sin_left   (sin_left),
    .stg        (stg),
    .sout_left  (sout_left),
    .sout_right (sout_right)
);

// File: tb/test_bidir_ring_shifter.sv
`timescale 1ns/1ps
module test_bidir_ring_shifter;

    localparam int N  = 32;
    localparam int CN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_left = 1'b0, feed_ext = 1'b1, hold = 1'b0;
    logic sin_r = 1'b0, sin_l = 1'b0;
    logic so_l, so_r, a_so_l, a_so_r, b_so_l, b_so_r;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    bit mq[$];
    bit cq[$];

    always #10 clk = ~clk;

    bidir_ring_shifter #(.STAGES(N)) i_bidir_ring_shifter (
        .clk(clk), .rst(rst), .dir_left(dir_left), .feed_ext(feed_ext), .hold(hold),
        .sin_right(sin_r), .sin_left(sin_l), .sout_left(so_l), .sout_right(so_r)
    );

    // R9: two short instances chained into one longer register
    bidir_ring_shifter #(.STAGES(CN)) i_bidir_ring_shifter_a (
        .clk(clk), .rst(rst), .dir_left(dir_left), .feed_ext(1'b1), .hold(hold),
        .sin_right(sin_r), .sin_left(b_so_l), .sout_left(a_so_l), .sout_right(a_so_r)
    );

    bidir_ring_shifter #(.STAGES(CN)) i_bidir_ring_shifter_b (
        .clk(clk), .rst(rst), .dir_left(dir_left), .feed_ext(1'b1), .hold(hold),
        .sin_right(a_so_r), .sin_left(sin_l), .sout_left(b_so_l), .sout_right(b_so_r)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(ref bit q[$], input logic d, input logic e, input logic h,
                              input logic r, input logic l);
        bit nb;
        if (!h) begin
            if (!d) begin
                nb = e ? bit'(r) : q[q.size()-1];
                void'(q.pop_back());
                q.push_front(nb);
            end else begin
                nb = e ? bit'(l) : q[0];
                void'(q.pop_front());
                q.push_back(nb);
            end
        end
    endtask

    task automatic clear_models();
        mq.delete();
        cq.delete();
        for (int k = 0; k < N; k++) mq.push_back(1'b0);
        for (int k = 0; k < 2*CN; k++) cq.push_back(1'b0);
    endtask

    // Entered and left in the low phase of the clock (R8: controls move only there).
    task automatic cycle(input string tag, input logic d, input logic e, input logic h,
                         input logic r, input logic l);
        bit om0, omn, oc0, ocn;
        dir_left = d; feed_ext = e; hold = h; sin_r = r; sin_l = l;
        om0 = mq[0]; omn = mq[N-1]; oc0 = cq[0]; ocn = cq[2*CN-1];
        @(posedge clk);
        model_step(mq, d, e, h, r, l);
        model_step(cq, d, 1'b1, h, r, l);
        #3;
        check("R7", "sout_left high phase", so_l, om0);
        check("R7", "sout_right high phase", so_r, omn);
        check("R9", "cascade left high phase", a_so_l, oc0);
        check("R9", "cascade right high phase", b_so_r, ocn);
        @(negedge clk);
        #3;
        check(tag, "sout_left", so_l, mq[0]);
        check(tag, "sout_right", so_r, mq[N-1]);
        check("R9", "cascade sout_left", a_so_l, cq[0]);
        check("R9", "cascade sout_right", b_so_r, cq[2*CN-1]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #3;
        clear_models();
        check("R1", "sout_left after reset", so_l, 1'b0);
        check("R1", "sout_right after reset", so_r, 1'b0);
        check("R1", "cascade left after reset", a_so_l, 1'b0);
        check("R1", "cascade right after reset", b_so_r, 1'b0);
        rst = 1'b0;
    endtask

    function automatic string tag_of(input logic d, input logic e, input logic h);
        if (h) return "R6";
        if (!d) return e ? "R2" : "R4";
        return e ? "R3" : "R5";
    endfunction

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat;
        pat = 32'hC5A3_9E17;
        clear_models();
        @(negedge clk);
        #3;
        do_reset();

        for (int i = 0; i < 40; i++) cycle("R2", 1'b0, 1'b1, 1'b0, pat[i%32], ~pat[(i+5)%32]);
        for (int i = 0; i < 40; i++) cycle("R3", 1'b1, 1'b1, 1'b0, pat[(i+9)%32], pat[(i*3)%32]);
        // R4: ring, sin_right toggles and must not matter
        for (int i = 0; i < 70; i++) cycle("R4", 1'b0, 1'b0, 1'b0, i[0], ~i[0]);
        // R5: ring, sin_left toggles and must not matter
        for (int i = 0; i < 70; i++) cycle("R5", 1'b1, 1'b0, 1'b0, ~i[1], i[0]);
        // R6: hold mixed with every mode
        for (int i = 0; i < 40; i++) begin
            logic h;
            h = (i % 3) != 2;
            cycle(tag_of(i[0], i[1], h), i[0], i[1], h, i[2], ~i[2]);
        end

        do_reset();

        for (int i = 0; i < 400; i++) begin
            logic d, e, h;
            d = 1'($urandom);
            e = ($urandom % 4) != 0;
            h = ($urandom % 5) == 0;
            cycle(tag_of(d, e, h), d, e, h, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule